// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter with Cascade Carry

This block is an up-counter whose state changes only on the rising clock edge. On each edge it either zeroes itself, takes a parallel preset word, advances by one, or holds. Which of these happens depends only on the control inputs as sampled at that edge. Zeroing and presetting are synchronous. No asynchronous path reaches the state.

Two enables gate counting. The parallel enable gates only the advance. The trickle enable gates the advance and also qualifies the carry output. The carry is combinational and rises while the count is all ones and the trickle enable is high. Several stages can therefore be chained: each stage's carry drives the next stage's trickle enable, and all stages share the parallel enable. A width parameter sets the number of count bits. The default is 4.

Top module: `sync_preset_counter`

## Requirements
- R1: When `clearN` is low at a rising edge, `count` is all zeros after that edge, whatever the other inputs are.
- R2: When `loadN` is low and `clearN` is high at a rising edge, `count` equals `presetData` after that edge. Every value from 0 to 2^WIDTH-1 is accepted, and no advance takes place.
- R3: When `clearN`, `loadN`, `parEn` and `trickleEn` are all high at a rising edge, `count` increases by one modulo 2^WIDTH. All ones therefore wraps to all zeros.
- R4: When `clearN` and `loadN` are high and either enable is low at a rising edge, `count` keeps its value.
- R5: When `clearN` and `loadN` are both low at the same edge, the result is zero: clear wins over load, and load wins over counting.
- R6: Pulses on the control inputs between rising edges leave `count` unchanged. Only the values present at the edge select the operation.
- R7: `carryOut` is high exactly when `count` is all ones and `trickleEn` is high. It follows `trickleEn` within the same cycle, and `parEn` has no effect on it.
- R8: Consider two WIDTH-bit stages that share clear, load and `parEn`, where the upper stage's `trickleEn` is driven by the lower stage's `carryOut`. This pair counts, loads and carries identically to a single 2*WIDTH-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clearN | input | 1 | Active-low synchronous clear |
| loadN | input | 1 | Active-low synchronous parallel preset |
| presetData | input | WIDTH | Value taken by the count on a preset |
| parEn | input | 1 | Parallel count enable; gates counting only |
| trickleEn | input | 1 | Trickle count enable; gates counting and the carry |
| count | output | WIDTH | Current count |
| carryOut | output | 1 | Terminal-count carry (all ones and trickleEn), combinational |

## Verification
The hardest case to reach from the ports is the cascade carry crossing from a stage at all ones into a neighbour that is itself at all ones. This case only matters when both stages are full at the same time. The stimulus reaches it in two ways: it presets a wide pair to values just below the double rollover, and it runs hundreds of cycles of mostly-enabled counting with scattered preset and hold cycles. The same-cycle dependence of the carry on the trickle enable is probed directly. That probe toggles the enable between edges while the count sits at all ones.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // One-hot (or all-zero) operation strobes from control to datapath.
  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
  } spcStrobe_t;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic       clearN,
  input  logic       loadN,
  input  logic       parEn,
  input  logic       trickleEn,
  output spcStrobe_t strobe
);
  // Priority: clear, then load, then counting.
  always_comb begin
    strobe = '0;
    if (!clearN)                strobe.clear   = 1'b1;
    else if (!loadN)            strobe.load    = 1'b1;
    else if (parEn && trickleEn) strobe.advance = 1'b1;
  end

  // R5: at most one operation is chosen at a time.
  always_comb begin
    if (!$isunknown(strobe))
      assert_single_op_R5: assert ($onehot0(strobe));
  end
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  spcStrobe_t       strobe,
  input  logic [WIDTH-1:0] presetData,
  input  logic             trickleEn,
  output logic [WIDTH-1:0] countQ,
  output logic             carryOut
);
  localparam logic [WIDTH-1:0] AllOnes = {WIDTH{1'b1}};

  logic [WIDTH-1:0] toggle;
  logic [WIDTH-1:0] countNext;

  // Look-ahead toggle chain: bit i flips when every lower bit is one.
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_tgl
      if (i == 0) begin : g_lsb
        assign toggle[i] = strobe.advance;
      end else begin : g_upper
        assign toggle[i] = strobe.advance & (&countQ[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    if (strobe.clear)      countNext = '0;
    else if (strobe.load)  countNext = presetData;
    else                   countNext = countQ ^ toggle;
  end

  always_ff @(posedge clk) countQ <= countNext;

  assign carryOut = (countQ == AllOnes) & trickleEn;

  assert_clear_R1: assert property (@(posedge clk) disable iff ($isunknown(countQ))
    strobe.clear |=> countQ == '0);
  assert_load_R2: assert property (@(posedge clk) disable iff ($isunknown(countQ))
    strobe.load |=> countQ == $past(presetData));
  assert_count_R3: assert property (@(posedge clk) disable iff ($isunknown(countQ))
    strobe.advance |=> countQ == WIDTH'($past(countQ) + 1'b1));
  assert_hold_R4: assert property (@(posedge clk) disable iff ($isunknown(countQ))
    !(strobe.clear || strobe.load || strobe.advance) |=> $stable(countQ));
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] presetData,
  input  logic             parEn,
  input  logic             trickleEn,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  spc_pkg::spcStrobe_t strobe;

  spc_ctrl u_ctrl (
    .clearN    (clearN),
    .loadN     (loadN),
    .parEn     (parEn),
    .trickleEn (trickleEn),
    .strobe    (strobe)
  );

  spc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .presetData (presetData),
    .trickleEn  (trickleEn),
    .countQ     (count),
    .carryOut   (carryOut)
  );

  // R7: carry only while full and trickle-enabled.
  assert_carry_R7: assert property (@(posedge clk) disable iff ($isunknown(count))
    carryOut |-> (count == {WIDTH{1'b1}} && trickleEn));
  // R3: counting from the carry state wraps to zero.
  assert_wrap_R3: assert property (@(posedge clk) disable iff ($isunknown(count))
    (carryOut && parEn && clearN && loadN) |=> count == '0);
endmodule

// File: tb/tb_sync_preset_counter.sv
`timescale 1ns/1ps
module tb_sync_preset_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       clearN = 1'b1, loadN = 1'b1, parEn = 1'b0, trickleEn = 1'b0;
  logic [3:0] presetData = '0;
  logic [3:0] count;
  logic       carryOut;

  sync_preset_counter #(.WIDTH(4)) dut (
    .clk(clk), .clearN(clearN), .loadN(loadN), .presetData(presetData),
    .parEn(parEn), .trickleEn(trickleEn), .count(count), .carryOut(carryOut));

  // Cascade pair versus one wide counter (R8).
  logic       cClrN = 1'b1, cLdN = 1'b1, cEn = 1'b0;
  logic [7:0] cData = '0;
  logic [3:0] loCnt, hiCnt;
  logic       loCarry, hiCarry;
  logic [7:0] wideCnt;
  logic       wideCarry;

  sync_preset_counter #(.WIDTH(4)) lo (
    .clk(clk), .clearN(cClrN), .loadN(cLdN), .presetData(cData[3:0]),
    .parEn(cEn), .trickleEn(cEn), .count(loCnt), .carryOut(loCarry));
  sync_preset_counter #(.WIDTH(4)) hi (
    .clk(clk), .clearN(cClrN), .loadN(cLdN), .presetData(cData[7:4]),
    .parEn(cEn), .trickleEn(loCarry), .count(hiCnt), .carryOut(hiCarry));
  sync_preset_counter #(.WIDTH(8)) wide (
    .clk(clk), .clearN(cClrN), .loadN(cLdN), .presetData(cData),
    .parEn(cEn), .trickleEn(cEn), .count(wideCnt), .carryOut(wideCarry));

  typedef struct {
    logic [3:0] expCount;
    string      tag;
  } item_t;
  item_t sbQ[$];

  int checks = 0, fails = 0;
  logic [3:0] model = '0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: apply one edge's inputs and push the expected result.
  task automatic step(input logic c, input logic l, input logic [3:0] d,
                      input logic p, input logic t, input string tag);
    item_t it;
    @(negedge clk);
    clearN = c; loadN = l; presetData = d; parEn = p; trickleEn = t;
    if (!c)          model = 4'd0;
    else if (!l)     model = d;
    else if (p && t) model = model + 4'd1;
    it.expCount = model; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: sample 5 ns after each rising edge.
  always @(posedge clk) begin
    #5;
    if (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      check({it.tag, " count"}, {4'd0, count}, {4'd0, it.expCount});
      check("R7 carry", {7'd0, carryOut},
            {7'd0, (it.expCount == 4'hF) && trickleEn});
    end
  end

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state via clear with load also low (R5).
    step(0, 0, 4'hA, 1, 1, "R5 clear beats load");
    step(1, 1, 4'h0, 1, 1, "R3 count");
    step(1, 1, 4'h0, 1, 1, "R3 count");
    step(1, 1, 4'h0, 0, 1, "R4 hold parEn low");
    step(1, 1, 4'h0, 1, 0, "R4 hold trickleEn low");
    step(1, 0, 4'h9, 1, 1, "R2 load beats count");
    step(0, 1, 4'h0, 1, 1, "R1 clear");
    for (int v = 0; v < 16; v++) step(1, 0, v[3:0], 0, 0, "R2 preset value");
    step(1, 0, 4'hE, 0, 0, "R2 preset");
    step(1, 1, 4'h0, 1, 1, "R3 to all ones");
    step(1, 1, 4'h0, 1, 1, "R3 wrap to zero");
    for (int k = 0; k < 20; k++) step(1, 1, 4'h0, 1, 1, "R3 run");

    // R7: carry follows trickleEn within the cycle; parEn has no effect.
    step(1, 0, 4'hF, 0, 1, "R2 preset F");
    @(negedge clk);
    trickleEn = 1'b0; parEn = 1'b1; #1;
    check("R7 carry off with trickle low", {7'd0, carryOut}, 8'd0);
    parEn = 1'b0; trickleEn = 1'b1; #1;
    check("R7 carry on with parEn low", {7'd0, carryOut}, 8'd1);
    loadN = 1'b1; #1;
    step(1, 1, 4'h0, 0, 1, "R4 hold at F");

    // R6: control pulses between edges do nothing.
    @(negedge clk);
    clearN = 1'b0; loadN = 1'b0; presetData = 4'h3; parEn = 1'b1; #3;
    clearN = 1'b1; loadN = 1'b1; parEn = 1'b0; #2;
    check("R6 no mid-cycle change", {4'd0, count}, {4'd0, model});
    step(1, 1, 4'h0, 0, 1, "R6 pulses ignored at edge");
    step(1, 1, 4'h0, 1, 1, "R3 wrap after pulses");
    wait (sbQ.size() == 0);
    @(negedge clk);

    // R8: cascade versus wide counter.
    cClrN = 1'b0; cEn = 1'b1;
    @(negedge clk); cClrN = 1'b1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      cLdN = 1'b1;
      cEn  = (n % 7) != 3;
      if (n == 5)        begin cLdN = 1'b0; cData = 8'hFD; end
      else if (n == 60)  begin cLdN = 1'b0; cData = 8'h0E; end
      else if (n == 200) begin cLdN = 1'b0; cData = 8'hEF; end
      #1;
      check("R8 cascade carry", {7'd0, hiCarry}, {7'd0, wideCarry});
      @(posedge clk); #5;
      check("R8 cascade count", {hiCnt, loCnt}, wideCnt);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule